// File: doc/BRIEF.md
# Binary Mux-Tree Serializer

The block turns parallel words into a single serial bit stream with a binary tree of 2:1 multiplexers. It does not use one load-and-shift register. A word of `WIDTH` bits (16 by default) is registered once per word period. It then passes through `log2(WIDTH)` levels. Each level halves the number of lanes and doubles the rate at which its lanes change, so 16 lanes become 8, then 4, then 2, and finally the single serial output. Every level has a flip-flop on each of its outputs. The next level's mux therefore always selects between registered, settled values.

Everything runs on one fast clock, with one rising edge per serial bit. The slower rates of the levels come from a chain of toggle flip-flops built from the same kind of flop as the data path. The chain's state is decoded into a load enable and a select for each level. Each level is offset by one edge from the level before it, so each lane is loaded one edge after its source has settled. A synchronous, active-high reset clears the divider and all data flops. This fixes the phase of every level, so the first serial bits after reset come in a known order.

Upstream logic sees `wd_strobe`, which marks the cycle whose closing edge samples `din`. It presents a new word in that cycle.

Top module: `mux_tree_serializer`

## Requirements
- R1: While `rst` is high, `sout` and `wd_strobe` are 0 from the first edge on. After release, `wd_strobe` is first high in cycle 15, counting the cycle after the first released edge as cycle 1.
- R2: `wd_strobe` is high for exactly one cycle in every `WIDTH` cycles. After release it is high in the cycles numbered 15, 31, 47, and so on.
- R3: `din` is sampled only on the rising edge that ends a `wd_strobe` cycle. Changes to `din` in any other cycle have no effect on the serial stream.
- R4: The stream is LSB first. Bit 0 of a captured word is on `sout` after the fourth edge that follows its capture edge (`log2(WIDTH)` edges). Bit i follows i cycles later, and each bit lasts exactly one cycle.
- R5: Consecutive words are sent with no gap: bit 15 of word n is followed directly by bit 0 of word n+1.
- R6: After reset, `sout` stays 0 until the first captured word arrives, which happens after 20 edges (`WIDTH + log2(WIDTH)`).
- R7: In level k, lane j selects between lane j and lane j+lanes of the level before it. Each lane register holds its value except on that level's load edge, so it is stable for the whole select period of the next level.
- R8: A reset applied in the middle of a word drops the word in flight and realigns every level. After release, timing and bit order are again exactly as in R1, R4 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock, one rising edge per serial bit |
| rst | input | 1 | Synchronous active-high reset of divider and data path |
| din | input | WIDTH | Parallel word, sampled at the edge ending a `wd_strobe` cycle |
| wd_strobe | output | 1 | High in the cycle whose closing edge captures `din` |
| sout | output | 1 | Serial output, LSB first |

## Verification
The capture of a new word and the draining of the previous word's upper bits through the lower levels happen on the same edge. The same holds for the top level loading its second half while the last level is still sending early bits. The bench provokes these collisions by sending words back to back with no idle periods. It starts with directed patterns (single-bit 0x0001 and 0x8000, all ones next to all zeros, alternating 0xAAAA and 0x5555) and continues with seeded random words. A bench-side deserializer rebuilds each word at the fixed latency and compares it whole, so any lost, duplicated or misplaced bit at a word seam shows up as a mismatch. A reset is also applied in the middle of a word, to collide with a capture still in flight. The bench then checks that the restarted stream begins exactly as after the first reset.

// File: rtl/ser_tree_pkg.sv
package ser_tree_pkg;

    // Per-level control: when a level's lane registers load, and which half they take
    typedef struct packed {
        logic load;
        logic sel;
    } lvl_ctl_t;

    // Lanes present at tree level k (level 0 is the captured word)
    function automatic int lanes_at(input int width, input int level);
        return width >> level;
    endfunction

    // Start index of tree level k (k >= 1) inside the flattened lane vector
    function automatic int flat_base(input int width, input int level);
        return width - (width >> (level - 1));
    endfunction

endpackage

// File: rtl/bit_clock_divider.sv
// Chain of toggle flops: stage i flips when all faster stages are high,
// so stage i runs at the bit rate divided by 2^(i+1).
module bit_clock_divider #(
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              rst,
    output logic [STAGES-1:0] phase
);
    logic [STAGES-1:0] tq;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic carry;
        if (i == 0) begin : g_first
            assign carry = 1'b1;
        end else begin : g_rest
            assign carry = &tq[i-1:0];
        end
        always_ff @(posedge clk) begin
            if (rst) tq[i] <= 1'b0;
            else     tq[i] <= tq[i] ^ carry;
        end
    end

    assign phase = tq;
endmodule

// File: rtl/level_phase_decode.sv
// Level k loads one edge after level k-1 by shifting the shared phase by k-1.
module level_phase_decode
    import ser_tree_pkg::*;
#(
    parameter int LEVELS = 4,
    parameter int LEVEL  = 1
) (
    input  logic [LEVELS-1:0] phase,
    output lvl_ctl_t          ctl
);
    localparam int SHIFT = LEVELS - LEVEL;
    localparam logic [LEVELS-1:0] MASK   = LEVELS'((1 << SHIFT) - 1);
    localparam logic [LEVELS-1:0] OFFSET = LEVELS'(LEVEL - 1);

    logic [LEVELS-1:0] rel;

    always_comb begin
        rel      = phase - OFFSET;
        ctl.load = ((rel & MASK) == '0);
        ctl.sel  = rel[SHIFT];
    end
endmodule

// File: rtl/mux_stage.sv
// One tree level: LANES registered 2:1 muxes, lane j picks src[j] or src[j+LANES].
module mux_stage #(
    parameter int LANES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               sel,
    input  logic [2*LANES-1:0] src,
    output logic [LANES-1:0]   q
);
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)       q[j] <= 1'b0;
            else if (load) q[j] <= sel ? src[j + LANES] : src[j];
        end
    end
endmodule

// File: rtl/mux_tree_serializer.sv
module mux_tree_serializer
    import ser_tree_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic             wd_strobe,
    output logic             sout
);
    localparam int LEVELS    = $clog2(WIDTH);
    localparam int TREE_BITS = WIDTH - 1;

    logic [LEVELS-1:0]    phase;
    logic [WIDTH-1:0]     word_q;
    logic [TREE_BITS-1:0] tree_q;
    logic [LEVELS:1]      lvl_load;

    bit_clock_divider #(.STAGES(LEVELS)) u_div (
        .clk   (clk),
        .rst   (rst),
        .phase (phase)
    );

    // Word rate: last phase of the period, captured on the closing edge
    assign wd_strobe = (phase == LEVELS'(WIDTH - 1));

    always_ff @(posedge clk) begin
        if (rst)            word_q <= '0;
        else if (wd_strobe) word_q <= din;
    end

    for (genvar k = 1; k <= LEVELS; k++) begin : g_level
        localparam int LANES = lanes_at(WIDTH, k);
        localparam int BASE  = flat_base(WIDTH, k);

        lvl_ctl_t             ctl;
        logic [2*LANES-1:0]   src;

        level_phase_decode #(.LEVELS(LEVELS), .LEVEL(k)) u_dec (
            .phase (phase),
            .ctl   (ctl)
        );

        if (k == 1) begin : g_src_word
            assign src = word_q;
        end else begin : g_src_tree
            assign src = tree_q[flat_base(WIDTH, k-1) +: 2*LANES];
        end

        mux_stage #(.LANES(LANES)) u_stage (
            .clk  (clk),
            .rst  (rst),
            .load (ctl.load),
            .sel  (ctl.sel),
            .src  (src),
            .q    (tree_q[BASE +: LANES])
        );

        assign lvl_load[k] = ctl.load;
    end

    assign sout = tree_q[TREE_BITS-1];
endmodule

// File: rtl/mux_tree_serializer_chk.sv
module mux_tree_serializer_chk #(
    parameter int WIDTH = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic [WIDTH-1:0]      din,
    input logic                  wd_strobe,
    input logic                  sout,
    input logic [WIDTH-1:0]      word_q,
    input logic [WIDTH-2:0]      tree_q,
    input logic [$clog2(WIDTH):1] lvl_load
);
    localparam int LEVELS = $clog2(WIDTH);
    localparam int QUIET  = WIDTH + LEVELS;
    localparam int CW     = $clog2(QUIET + 1) + 1;

    logic          rst_d;
    logic [CW-1:0] since_rst;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst)                        since_rst <= '0;
        else if (since_rst < CW'(QUIET)) since_rst <= since_rst + 1'b1;
    end

    // R1: an edge taken in reset leaves output and strobe low
    always @(posedge clk) begin
        if (rst_d == 1'b1) begin
            p_reset_clear_r1: assert (sout == 1'b0 && wd_strobe == 1'b0);
        end
    end

    // R2
    p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
        wd_strobe |=> !wd_strobe);

    // R3
    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        wd_strobe |=> (word_q == $past(din)));

    p_word_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !wd_strobe |=> $stable(word_q));

    // R6
    p_quiet_start_r6: assert property (@(posedge clk) disable iff (rst)
        (since_rst < CW'(QUIET)) |-> (sout == 1'b0));

    // R7
    for (genvar k = 1; k <= LEVELS; k++) begin : g_hold
        localparam int LANES = WIDTH >> k;
        localparam int BASE  = WIDTH - (WIDTH >> (k - 1));
        p_level_hold_r7: assert property (@(posedge clk) disable iff (rst)
            !lvl_load[k] |=> $stable(tree_q[BASE +: LANES]));
    end
endmodule

bind mux_tree_serializer mux_tree_serializer_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .din       (din),
    .wd_strobe (wd_strobe),
    .sout      (sout),
    .word_q    (word_q),
    .tree_q    (tree_q),
    .lvl_load  (lvl_load)
);

// File: tb/test_mux_tree_serializer.sv
module test_mux_tree_serializer;
    localparam int W   = 16;
    localparam int L   = 4;
    localparam int LAT = W + L;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] din = '0;
    logic         wd_strobe;
    logic         sout;

    int n_chk = 0;
    int n_bad = 0;
    int dir_idx = 0;
    bit done = 1'b0;
    logic [W-1:0] words [0:255];

    always #10 clk = ~clk;

    mux_tree_serializer #(.WIDTH(W)) i_mux_tree_serializer (
        .clk       (clk),
        .rst       (rst),
        .din       (din),
        .wd_strobe (wd_strobe),
        .sout      (sout)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pick_word();
        logic [W-1:0] v;
        case (dir_idx)
            0: v = 16'h0001;
            1: v = 16'h8000;
            2: v = 16'hFFFF;
            3: v = 16'h0000;
            4: v = 16'hAAAA;
            5: v = 16'h5555;
            6: v = 16'hFFFF;
            7: v = 16'h0001;
            default: v = W'($urandom);
        endcase
        dir_idx++;
        return v;
    endfunction

    // Release reset, then follow the stream for the given number of cycles.
    // Cycle c is observed at the falling edge after the c-th released rising edge.
    task automatic run_stream(input int cycles, input bit noise);
        logic [W-1:0] rx = '0;
        int nw = 0;
        @(negedge clk) rst = 1'b0;
        for (int cyc = 1; cyc <= cycles; cyc++) begin
            @(negedge clk);
            check(wd_strobe == ((cyc % W) == W - 1), "R2 strobe period (R1 first at 15)",
                  32'(wd_strobe), 32'((cyc % W) == W - 1));
            if (cyc < LAT) begin
                check(sout == 1'b0, "R6 quiet before first word", 32'(sout), 32'd0);
            end else begin
                int idx = cyc - LAT;
                int b   = idx % W;
                int f   = idx / W;
                rx[b] = sout;
                if (b == W - 1) begin
                    check(rx == words[f], "R4 R5 recovered word (R3 noise)", 32'(rx), 32'(words[f]));
                end
            end
            if (wd_strobe) begin
                words[nw] = pick_word();
                din = words[nw];
                nw++;
            end else if (noise) begin
                din = W'($urandom);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd2718));
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check(sout == 1'b0, "R1 reset sout", 32'(sout), 32'd0);
        check(wd_strobe == 1'b0, "R1 reset strobe", 32'(wd_strobe), 32'd0);

        run_stream(W * 40 + 27, 1'b1);

        // R8: reset in the middle of a word
        @(negedge clk) rst = 1'b1;
        repeat (2) begin
            @(negedge clk);
            check(sout == 1'b0, "R8 mid-word reset sout", 32'(sout), 32'd0);
            check(wd_strobe == 1'b0, "R8 mid-word reset strobe", 32'(wd_strobe), 32'd0);
        end
        run_stream(W * 30 + 9, 1'b0);

        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        check(sout == 1'b0, "R8 second reset sout", 32'(sout), 32'd0);
        run_stream(W * 100, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule